// File: doc/BRIEF.md
# SM3 Message Expansion Step Unit

This unit carries out one of the two partial steps that extend an SM3 message schedule by four words. Each call presents three packed 128-bit operands (four 32-bit words each) and a one-bit step select. The unit returns one packed 128-bit result one clock after the call is accepted. Step one mixes older schedule words into four intermediate words. Step two takes those intermediates and produces the next four finished schedule words. The last word of step two depends on the first word that the same step produces.

Calls arrive on a valid/ready input stream, and results leave on a valid/ready output stream. A single output register sits between the two streams. A call is accepted in any cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. When the consumer holds `out_ready` low, the held result stays unchanged and `in_ready` drops. A source must keep its operands and step select steady while it waits for acceptance. The surrounding software or logic decides the order of calls across the full schedule.

Top module: `sm3_msgexp_unit`

## Requirements
- R1: Reset (synchronous, active high) empties the output register: `out_valid` reads 0 in the cycle after reset, even if a result was pending before it.
- R2: With `op_sel`=0 (step one), output lane k (k=0,1,2) equals P1(A[k] ^ C[k] ^ rol(B[k],15)). Here P1(x)=x^rol(x,15)^rol(x,23), rol is a 32-bit left rotate, and X[k] is bits 32k+31:32k of operand X.
- R3: With `op_sel`=0, output lane 3 equals P1(A[3] ^ C[3]), with no rotated term. Bits 127:96 of operand B have no effect on any output bit.
- R4: With `op_sel`=1 (step two), output lane k (k=0,1,2) equals rol(B[k],7) ^ C[k] ^ A[k].
- R5: With `op_sel`=1, output lane 3 equals U3 ^ rol(U0,6) ^ rol(U0,15) ^ rol(U0,30), where Uk = rol(B[k],7) ^ C[k] ^ A[k].
- R6: Lane k of the result occupies `out_data` bits 32k+31:32k, so lane 0 is in the low 32 bits.
- R7: An accepted call shows up with `out_valid`=1 exactly one cycle later. If no call is accepted and the output is drained or already empty, `out_valid` is 0 in the next cycle.
- R8: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_valid` hold, `in_ready` is 0, and a waiting call is not taken.
- R9: `op_sel` is sampled only in the cycle the call is accepted. Its value in other cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A call is being offered |
| in_ready | output | 1 | The unit can take a call this cycle |
| op_sel | input | 1 | 0 selects step one, 1 selects step two |
| opnd_a | input | 128 | First operand, four packed words |
| opnd_b | input | 128 | Second operand, four packed words |
| opnd_c | input | 128 | Third operand, four packed words |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 128 | Result, four packed words |

## Verification
Two things can happen in the same clock edge: the held result can be drained and a new call can be accepted. The bench first stalls the output with a call waiting. It then raises `out_ready` while that call is still offered. The result is judged correct when the old result stays unchanged through the stall and the next cycle shows the new call's result with `out_valid` still high, with no empty cycle in between. Both step computations are compared against values the bench derives on its own, including hand-worked single-bit cases that pin down lane order and the lane-3 feedback.

// File: rtl/sm3x_pkg.sv
package sm3x_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = 4;
  localparam int VEC_W  = WORD_W * LANES;

  typedef logic [WORD_W-1:0] word_t;

  // Left rotate, count reduced modulo the word width.
  function automatic word_t rol(input word_t x, input int n);
    int s;
    s = n % WORD_W;
    if (s == 0) return x;
    return (x << s) | (x >> (WORD_W - s));
  endfunction

  // Linear mixing used at the end of step one.
  function automatic word_t mix_p1(input word_t x);
    return x ^ rol(x, 15) ^ rol(x, 23);
  endfunction

  // Feedback term applied to the last lane of step two.
  function automatic word_t fold_fb(input word_t x);
    return rol(x, 6) ^ rol(x, 15) ^ rol(x, 30);
  endfunction
endpackage

// File: rtl/sm3x_step_one.sv
module sm3x_step_one
  import sm3x_pkg::*;
(
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic [VEC_W-1:0] c,
  output logic [VEC_W-1:0] y
);
  localparam int LAST = LANES - 1;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    word_t t;
    if (k < LAST) begin : g_rot
      assign t = a[k*WORD_W +: WORD_W] ^ c[k*WORD_W +: WORD_W]
               ^ rol(b[k*WORD_W +: WORD_W], 15);
    end else begin : g_plain
      assign t = a[k*WORD_W +: WORD_W] ^ c[k*WORD_W +: WORD_W];
    end
    assign y[k*WORD_W +: WORD_W] = mix_p1(t);
  end

  // The top word of b takes no part in this step.
  logic unused_b_top;
  assign unused_b_top = ^b[LAST*WORD_W +: WORD_W];
endmodule

// File: rtl/sm3x_step_two.sv
module sm3x_step_two
  import sm3x_pkg::*;
(
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic [VEC_W-1:0] c,
  output logic [VEC_W-1:0] y
);
  localparam int LAST = LANES - 1;

  word_t u [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign u[k] = rol(b[k*WORD_W +: WORD_W], 7) ^ c[k*WORD_W +: WORD_W]
                ^ a[k*WORD_W +: WORD_W];
    if (k < LAST) begin : g_direct
      assign y[k*WORD_W +: WORD_W] = u[k];
    end else begin : g_fed
      assign y[k*WORD_W +: WORD_W] = u[k] ^ fold_fb(u[0]);
    end
  end
endmodule

// File: rtl/sm3x_out_stage.sv
module sm3x_out_stage #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  logic         full_q;
  logic [W-1:0] data_q;
  logic         take;

  assign in_ready = !full_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
    end else if (take) begin
      full_q <= 1'b1;
    end else if (out_ready) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) data_q <= d;
  end

  assign out_valid = full_q;
  assign q         = data_q;
endmodule

// File: rtl/sm3_msgexp_unit.sv
module sm3_msgexp_unit
  import sm3x_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             op_sel,
  input  logic [VEC_W-1:0] opnd_a,
  input  logic [VEC_W-1:0] opnd_b,
  input  logic [VEC_W-1:0] opnd_c,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data
);
  logic [VEC_W-1:0] res_one;
  logic [VEC_W-1:0] res_two;
  logic [VEC_W-1:0] res_sel;

  sm3x_step_one u_one (.a(opnd_a), .b(opnd_b), .c(opnd_c), .y(res_one));
  sm3x_step_two u_two (.a(opnd_a), .b(opnd_b), .c(opnd_c), .y(res_two));

  assign res_sel = op_sel ? res_two : res_one;

  sm3x_out_stage #(.W(VEC_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .d        (res_sel),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .q        (out_data)
  );
endmodule

// File: rtl/sm3x_checker.sv
module sm3x_checker
  import sm3x_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             op_sel,
  input logic [VEC_W-1:0] opnd_a,
  input logic [VEC_W-1:0] opnd_c,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_data
);
  localparam int TOP = (LANES - 1) * WORD_W;

  assert_reset_empty_R1: assert property (@(posedge clk)
    rst |=> !out_valid);

  assert_accept_lat_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  assert_drain_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (!(in_valid && in_ready) && !(out_valid && !out_ready)) |=> !out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_no_take_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_lane3_one_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !op_sel) |=>
      (out_data[TOP +: WORD_W] ==
       mix_p1($past(opnd_a[TOP +: WORD_W]) ^ $past(opnd_c[TOP +: WORD_W]))));
endmodule

bind sm3_msgexp_unit sm3x_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .op_sel   (op_sel),
  .opnd_a   (opnd_a),
  .opnd_c   (opnd_c),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/sim_sm3_msgexp_unit.sv
module sim_sm3_msgexp_unit;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         op_sel = 1'b0;
  logic [127:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  sm3_msgexp_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // ---- independent reference ----
  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    logic [63:0] dbl;
    dbl = {x, x} << (n % 32);
    return dbl[63:32];
  endfunction
  function automatic logic [31:0] pmix(input logic [31:0] x);
    return x ^ rl(x, 15) ^ rl(x, 23);
  endfunction
  function automatic logic [31:0] wd(input logic [127:0] v, input int k);
    return v[k*32 +: 32];
  endfunction
  function automatic logic [127:0] ref_one(input logic [127:0] a, b, c);
    logic [127:0] r;
    for (int k = 0; k < 3; k++)
      r[k*32 +: 32] = pmix(wd(a,k) ^ wd(c,k) ^ rl(wd(b,k), 15));
    r[127:96] = pmix(wd(a,3) ^ wd(c,3));
    return r;
  endfunction
  function automatic logic [127:0] ref_two(input logic [127:0] a, b, c);
    logic [127:0] r;
    for (int k = 0; k < 4; k++)
      r[k*32 +: 32] = rl(wd(b,k), 7) ^ wd(c,k) ^ wd(a,k);
    r[127:96] = r[127:96] ^ rl(r[31:0], 6) ^ rl(r[31:0], 15) ^ rl(r[31:0], 30);
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // One accepted call, result checked at the following negedge.
  task automatic call(input logic op, input logic [127:0] a, b, c,
                      input string req, input logic [127:0] exp);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b; opnd_c = c;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {127'd0, out_valid}, 128'd1);
    chk(req, out_data, exp);
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 valid after reset", {127'd0, out_valid}, 128'd0);
    rst = 1'b0;
    // Park a result, then reset over it.
    @(negedge clk);
    in_valid = 1'b1; out_ready = 1'b0; opnd_a = 128'h5;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 pre-reset pending", {127'd0, out_valid}, 128'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; out_ready = 1'b1;
    chk("R1 reset drops pending", {127'd0, out_valid}, 128'd0);
    chk("R1 ready after reset", {127'd0, in_ready}, 128'd1);
  endtask

  task automatic t_step_one;
    logic [127:0] a, b, c, e;
    a = 128'h0123456789abcdef_fedcba9876543210;
    b = 128'hdeadbeef_cafef00d_13579bdf_2468ace0;
    c = 128'h0f0f0f0f_f0f0f0f0_33333333_cccccccc;
    e = ref_one(a, b, c);
    call(1'b0, a, b, c, "R2 step one pattern A", e);
    chk("R3 step one lane3 A", {96'd0, out_data[127:96]}, {96'd0, pmix(wd(a,3) ^ wd(c,3))});
    a = '1; b = 128'h80000000_00000001_80000000_00000001; c = '0;
    call(1'b0, a, b, c, "R2 step one pattern B", ref_one(a, b, c));
    a = 128'h11111111_22222222_33333333_44444444;
    call(1'b0, a, a, a, "R2 step one pattern C", ref_one(a, a, a));
  endtask

  task automatic t_ignore_b3;
    logic [127:0] a, b, c, e;
    a = 128'h9e3779b9_7f4a7c15_f39cc060_5cedc834;
    c = 128'h243f6a88_85a308d3_13198a2e_03707344;
    b = 128'h00000000_a4093822_299f31d0_082efa98;
    e = ref_one(a, b, c);
    call(1'b0, a, b, c, "R3 B top zero", e);
    b[127:96] = 32'hffffffff;
    call(1'b0, a, b, c, "R3 B top ones ignored", e);
    b[127:96] = 32'h5a5aa5a5;
    call(1'b0, a, b, c, "R3 B top mixed ignored", e);
  endtask

  task automatic t_step_two;
    logic [127:0] a, b, c, e;
    a = 128'h6a09e667_bb67ae85_3c6ef372_a54ff53a;
    b = 128'h510e527f_9b05688c_1f83d9ab_5be0cd19;
    c = 128'hcbbb9d5d_629a292a_9159015a_152fecd8;
    e = ref_two(a, b, c);
    call(1'b1, a, b, c, "R4 step two pattern A", e);
    chk("R5 step two lane3 A", {96'd0, out_data[127:96]}, {96'd0, e[127:96]});
    a = '0; b = '1; c = 128'h0000ffff_ffff0000_00ff00ff_ff00ff00;
    call(1'b1, a, b, c, "R4 step two pattern B", ref_two(a, b, c));
  endtask

  task automatic t_order;
    // Hand-worked: single set bit in lane 0.
    call(1'b0, 128'h1, 128'h0, 128'h0, "R6 step one lane0 only",
         128'h00000000_00000000_00000000_00808001);
    call(1'b1, 128'h0, 128'h1, 128'h0, "R5 R6 step two feedback",
         128'h00402020_00000000_00000000_00000080);
  endtask

  task automatic t_latency;
    @(negedge clk);
    in_valid = 1'b1; op_sel = 1'b0; opnd_a = 128'h7; opnd_b = '0; opnd_c = '0;
    chk("R7 not yet valid", {127'd0, out_valid}, 128'd0);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 valid one cycle later", {127'd0, out_valid}, 128'd1);
    @(negedge clk);
    chk("R7 empties after drain", {127'd0, out_valid}, 128'd0);
  endtask

  task automatic t_stall;
    logic [127:0] a1, a2, e1, e2;
    a1 = 128'haaaa0000_bbbb1111_cccc2222_dddd3333;
    a2 = 128'h12340000_56781111_9abc2222_def03333;
    e1 = ref_one(a1, '0, '0);
    e2 = ref_two(a2, a1, '0);
    @(negedge clk);
    in_valid = 1'b1; op_sel = 1'b0; opnd_a = a1; opnd_b = '0; opnd_c = '0;
    out_ready = 1'b0;
    @(negedge clk);
    op_sel = 1'b1; opnd_a = a2; opnd_b = a1;     // next call waits
    chk("R8 first result", out_data, e1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 held data", out_data, e1);
      chk("R8 ready low", {127'd0, in_ready}, 128'd0);
    end
    out_ready = 1'b1;                              // drain and take together
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 back to back valid", {127'd0, out_valid}, 128'd1);
    chk("R8 waiting call result", out_data, e2);
    @(negedge clk);
    chk("R7 empty after last", {127'd0, out_valid}, 128'd0);
  endtask

  task automatic t_opsel;
    logic [127:0] a, b, c;
    a = 128'hfeedface_0badf00d_c001d00d_8badbeef;
    b = 128'h01010101_02020202_04040404_08080808;
    c = 128'h10203040_50607080_90a0b0c0_d0e0f000;
    // Toggle select with no call offered: output must stay empty.
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      op_sel = i[0];
      chk("R9 idle toggle no output", {127'd0, out_valid}, 128'd0);
    end
    call(1'b1, a, b, c, "R9 select at accept two", ref_two(a, b, c));
    call(1'b0, a, b, c, "R9 select at accept one", ref_one(a, b, c));
    // Select changes after acceptance while result is held.
    @(negedge clk);
    in_valid = 1'b1; op_sel = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; op_sel = 1'b0;
    @(negedge clk);
    chk("R9 later select no effect", out_data, ref_two(a, b, c));
    out_ready = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_step_one();
    t_ignore_b3();
    t_step_two();
    t_order();
    t_latency();
    t_stall();
    t_opsel();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule